// File: doc/BRIEF.md
# Dual-Trigger Up-Counter Pair

This block holds two independent 4-stage up-counters. Each counter has two count inputs that can swap roles. It advances on a rising edge of its `cnt_clk` input while `cnt_en` is high. It also advances on a falling edge of `cnt_en` while `cnt_clk` is low. A per-instance parameter selects decade counting (0 to 9) or binary counting (0 to 15). Each counter has its own active-high clear that forces it to zero.

Both count inputs are sampled on the system clock `sys_clk` through a synchronizer, and edges are found inside the block. This keeps the whole design synchronous. Counters can be chained in ripple fashion: the top output bit of one counter drives the enable input of the next, and that next counter's `cnt_clk` is held low. The next counter then advances each time the previous one wraps.

Top module: `dual_trig_counter`

## Requirements
- R1: While `cnt_mr[i]` is high at a `sys_clk` edge, counter i reads zero after that edge. Any count-input edges during that time have no effect.
- R2: A low-to-high change of `cnt_clk[i]` while `cnt_en[i]` is high adds one to counter i.
- R3: A high-to-low change of `cnt_en[i]` while `cnt_clk[i]` is low adds one to counter i.
- R4: The count does not change on any of these: a falling `cnt_clk`, a rising `cnt_en`, a rising `cnt_clk` with `cnt_en` low, or a falling `cnt_en` with `cnt_clk` high.
- R5: In decade mode the count goes from 9 to 0 and never shows a value above 9.
- R6: In binary mode the count goes from 15 to 0.
- R7: Releasing `cnt_mr` while count inputs are steady (even both high) causes no count.
- R8: A qualifying input change driven between two `sys_clk` edges shows on `cnt_q` after the third following rising edge, not before. There is at most one increment per edge.
- R9: Two counters chained with `cnt_q[3]` driving the next `cnt_en` and the next `cnt_clk` held low count through 00..99 in decade mode and 0..255 in binary mode, then return to zero.
- R10: Channel i's output occupies `cnt_q[4*i+3:4*i]` with its lowest bit the least significant. Clearing one channel leaves the other channel's count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock sampling all inputs |
| cnt_clk | input | 2 | Per-channel count input, rising edge active while enable high |
| cnt_en | input | 2 | Per-channel count input, falling edge active while clock input low |
| cnt_mr | input | 2 | Per-channel active-high clear, synchronous to `sys_clk` |
| cnt_q | output | 8 | Counts, channel i at bits 4*i+3 down to 4*i |

## Verification
The hardest case to reach is the rollover of a second chained counter, which needs the first counter's top bit to fall. In binary mode that happens only after 255 slow pulses, each held long enough for both synchronizers to see it. The bench wires the chain inside itself and drives only the first counter. It checks the combined value after every pulse, up to the final return to zero. The release of the clear with both inputs already high is reached directly from the vector table.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic {
      RADIX_BIN = 1'b0,
      RADIX_DEC = 1'b1
   } radix_e;

   localparam int DEC_TOP = 9;
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dtc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) chain[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dtc_edge_trig.sv
module dtc_edge_trig (
   input  logic clk,
   input  logic clr,
   input  logic cp_s,
   input  logic en_s,
   output logic step
);
   logic cp_prev, en_prev;
   logic cp_rise, en_fall;

   // History always reloads from the live samples, so it equals the input
   // level at clear release: no phantom edge is seen afterwards.
   always_ff @(posedge clk) begin
      cp_prev <= cp_s;
      en_prev <= en_s;
   end

   assign cp_rise = cp_s & ~cp_prev;
   assign en_fall = ~en_s & en_prev;
   assign step    = ~clr & ((cp_rise & en_s) | (en_fall & ~cp_s));

   // R4: a step only comes from a change on one of the sampled inputs
   a_r4_needs_change: assert property (@(posedge clk) disable iff (clr)
      step |-> ((cp_s != cp_prev) || (en_s != en_prev)));

   // R2/R3: each step is qualified by the level on the other input
   a_r3_qualified: assert property (@(posedge clk) disable iff (clr)
      step |-> ((cp_s && en_s) || (!cp_s && !en_s)));
endmodule

// File: rtl/dtc_count_core.sv
module dtc_count_core #(
   parameter int             CNT_W = 4,
   parameter dtc_pkg::radix_e RADIX = dtc_pkg::RADIX_DEC
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             step,
   output logic [CNT_W-1:0] q
);
   localparam logic [CNT_W-1:0] TOP_V =
      (RADIX == dtc_pkg::RADIX_DEC) ? CNT_W'(dtc_pkg::DEC_TOP) : {CNT_W{1'b1}};

   if (CNT_W < 4) begin : g_bad_width
      $error("dtc_count_core: CNT_W must be at least 4");
   end

   logic [CNT_W-1:0] nxt;

   if (RADIX == dtc_pkg::RADIX_DEC) begin : g_dec
      assign nxt = (q == TOP_V) ? '0 : q + 1'b1;
      // R5: decade value never passes nine
      a_r5_dec_range: assert property (@(posedge clk) disable iff (clr)
         q <= TOP_V);
   end else begin : g_bin
      assign nxt = q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (clr)       q <= '0;
      else if (step) q <= nxt;
   end

   // R1: clear drives the count to zero on the next edge
   a_r1_clear: assert property (@(posedge clk) clr |=> (q == '0));

   // R4/R8: without a step the count holds
   a_r8_hold: assert property (@(posedge clk) disable iff (clr)
      !step |=> $stable(q));

   // R2/R3: a step always moves the count
   a_r2_moves: assert property (@(posedge clk) disable iff (clr)
      step |=> (q != $past(q)));
endmodule

// File: rtl/dtc_unit.sv
module dtc_unit #(
   parameter int              CNT_W       = 4,
   parameter int              SYNC_STAGES = 2,
   parameter dtc_pkg::radix_e RADIX       = dtc_pkg::RADIX_DEC
) (
   input  logic             clk,
   input  logic             mr,
   input  logic             cp,
   input  logic             en,
   output logic [CNT_W-1:0] q
);
   logic cp_s, en_s, step;

   dtc_sync #(.STAGES(SYNC_STAGES)) u_sync_cp (.clk(clk), .d(cp), .q(cp_s));
   dtc_sync #(.STAGES(SYNC_STAGES)) u_sync_en (.clk(clk), .d(en), .q(en_s));

   dtc_edge_trig u_trig (
      .clk (clk),
      .clr (mr),
      .cp_s(cp_s),
      .en_s(en_s),
      .step(step)
   );

   dtc_count_core #(.CNT_W(CNT_W), .RADIX(RADIX)) u_core (
      .clk (clk),
      .clr (mr),
      .step(step),
      .q   (q)
   );
endmodule

// File: rtl/dual_trig_counter.sv
module dual_trig_counter #(
   parameter int              NCH         = 2,
   parameter int              CNT_W       = 4,
   parameter int              SYNC_STAGES = 2,
   parameter dtc_pkg::radix_e RADIX       = dtc_pkg::RADIX_DEC
) (
   input  logic                   sys_clk,
   input  logic [NCH-1:0]         cnt_clk,
   input  logic [NCH-1:0]         cnt_en,
   input  logic [NCH-1:0]         cnt_mr,
   output logic [NCH*CNT_W-1:0]   cnt_q
);
   if (NCH < 1) begin : g_bad_nch
      $error("dual_trig_counter: NCH must be at least 1");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dtc_unit #(
         .CNT_W      (CNT_W),
         .SYNC_STAGES(SYNC_STAGES),
         .RADIX      (RADIX)
      ) u_unit (
         .clk(sys_clk),
         .mr (cnt_mr[c]),
         .cp (cnt_clk[c]),
         .en (cnt_en[c]),
         .q  (cnt_q[c*CNT_W +: CNT_W])
      );
   end
endmodule

// File: tb/dual_trig_counter_test.sv
module dual_trig_counter_test;
   localparam int PERIOD = 10;

   logic       sys_clk = 1'b0;
   logic [1:0] d_clk, d_mr, b_clk, b_mr;
   logic       d_en0, b_en0;
   logic [7:0] d_q, b_q;
   wire  [1:0] d_en = {d_q[3], d_en0};
   wire  [1:0] b_en = {b_q[3], b_en0};

   int checks = 0;
   int errors = 0;

   always #(PERIOD/2) sys_clk = ~sys_clk;

   dual_trig_counter #(.RADIX(dtc_pkg::RADIX_DEC)) uut (
      .sys_clk(sys_clk), .cnt_clk(d_clk), .cnt_en(d_en), .cnt_mr(d_mr), .cnt_q(d_q));

   dual_trig_counter #(.RADIX(dtc_pkg::RADIX_BIN)) uut_bin (
      .sys_clk(sys_clk), .cnt_clk(b_clk), .cnt_en(b_en), .cnt_mr(b_mr), .cnt_q(b_q));

   // {mr, clk, en, expected ch0 count}
   localparam logic [6:0] VEC [16] = '{
      {1'b0, 1'b0, 1'b1, 4'd0},  // en rise, clk low
      {1'b0, 1'b1, 1'b1, 4'd1},  // clk rise, en high
      {1'b0, 1'b0, 1'b1, 4'd1},  // clk fall
      {1'b0, 1'b0, 1'b0, 4'd2},  // en fall, clk low
      {1'b0, 1'b1, 1'b0, 4'd2},  // clk rise, en low
      {1'b0, 1'b1, 1'b1, 4'd2},  // en rise, clk high
      {1'b0, 1'b1, 1'b0, 4'd2},  // en fall, clk high
      {1'b0, 1'b0, 1'b0, 4'd2},
      {1'b0, 1'b0, 1'b1, 4'd2},
      {1'b0, 1'b0, 1'b0, 4'd3},
      {1'b0, 1'b0, 1'b1, 4'd3},
      {1'b0, 1'b1, 1'b1, 4'd4},
      {1'b1, 1'b1, 1'b1, 4'd0},  // clear
      {1'b0, 1'b1, 1'b1, 4'd0},  // release with both high
      {1'b0, 1'b0, 1'b1, 4'd0},
      {1'b0, 1'b1, 1'b1, 4'd1}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge sys_clk);
   endtask

   task automatic d_pulse();
      @(negedge sys_clk) d_clk[0] = 1'b1;
      settle(4);
      d_clk[0] = 1'b0;
      settle(4);
   endtask

   task automatic b_pulse();
      @(negedge sys_clk) b_clk[0] = 1'b1;
      settle(4);
      b_clk[0] = 1'b0;
      settle(4);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      finish_run();
   end

   initial begin
      d_clk = '0; d_en0 = 1'b0; d_mr = 2'b11;
      b_clk = '0; b_en0 = 1'b0; b_mr = 2'b11;
      settle(6);
      check("R1 reset dec", int'(d_q), 0);
      check("R1 reset bin", int'(b_q), 0);
      d_mr = 2'b00; b_mr = 2'b00;
      settle(2);

      // table walk on decade channel 0 (R1 R2 R3 R4 R7)
      foreach (VEC[i]) begin
         @(negedge sys_clk);
         d_mr[0]  = VEC[i][6];
         d_clk[0] = VEC[i][5];
         d_en0    = VEC[i][4];
         settle(4);
         check($sformatf("R2/R3/R4 vec %0d", i), int'(d_q[3:0]), int'(VEC[i][3:0]));
      end

      // R8 latency: clk high at 1 now, drop then rise with en high
      @(negedge sys_clk) d_clk[0] = 1'b0;
      settle(4);
      @(negedge sys_clk) d_clk[0] = 1'b1;
      settle(2);
      check("R8 before third edge", int'(d_q[3:0]), 1);
      settle(1);
      check("R8 after third edge", int'(d_q[3:0]), 2);
      @(negedge sys_clk) d_clk[0] = 1'b0;
      settle(4);

      // R1: edges during clear ignored
      d_mr[0] = 1'b1;
      d_pulse();
      d_pulse();
      check("R1 edges under clear", int'(d_q[3:0]), 0);
      d_mr[0] = 1'b0;
      settle(2);

      // R5 decade wrap
      for (int k = 1; k <= 9; k++) d_pulse();
      check("R5 reaches 9", int'(d_q[3:0]), 9);
      d_pulse();
      check("R5 wraps to 0", int'(d_q[3:0]), 0);

      // R10 independence: clear channel 1 only, channel 0 keeps value
      d_mr = 2'b11; settle(3); d_mr = 2'b00; settle(2);
      for (int k = 0; k < 3; k++) d_pulse();
      d_mr[1] = 1'b1; settle(4);
      check("R10 ch0 kept", int'(d_q[3:0]), 3);
      check("R10 ch1 cleared", int'(d_q[7:4]), 0);
      d_mr[1] = 1'b0; settle(2);

      // R6 binary wrap via falling en with clk low (R3)
      for (int k = 1; k <= 15; k++) begin
         @(negedge sys_clk) b_en0 = 1'b1; settle(4);
         @(negedge sys_clk) b_en0 = 1'b0; settle(4);
      end
      check("R6 reaches 15", int'(b_q[3:0]), 15);
      @(negedge sys_clk) b_en0 = 1'b1; settle(4);
      @(negedge sys_clk) b_en0 = 1'b0; settle(4);
      check("R6 wraps to 0", int'(b_q[3:0]), 0);
      b_en0 = 1'b1;

      // R9 decade cascade to 99 and rollover
      d_mr = 2'b11; settle(3); d_mr = 2'b00; d_en0 = 1'b1; settle(2);
      for (int k = 1; k <= 100; k++) begin
         d_pulse();
         check("R9 dec cascade", int'(d_q[7:4]) * 10 + int'(d_q[3:0]), k % 100);
      end

      // R9 binary cascade to 255 and rollover
      b_mr = 2'b11; settle(3); b_mr = 2'b00; settle(2);
      for (int k = 1; k <= 256; k++) begin
         b_pulse();
         check("R9 bin cascade", int'(b_q), k % 256);
      end

      finish_run();
   end
endmodule